// File: doc/BRIEF.md
# Tracking ADC Up/Down Controller

This block is the digital half of a tracking analog-to-digital converter. It keeps a saturating up/down code that feeds an external DAC. A comparator outside the block compares the DAC output with the analog input and returns two flags. One flag says the test level is above the input. The other says the test level is below it. When neither flag is set, the two levels are equal.

After reset the code starts at zero and the block is in an acquisition phase. In this phase it only counts upward, one step per enabled clock, until the test level first reaches the input. After that it tracks without end. On every enabled clock it moves the code one step toward the input, or leaves it where it is when the levels are equal. A step-enable input gates every change, which lets the system pace the loop to the settling time of the DAC.

A locked output tells the system whether the code is sitting within one step of the input or is slewing after a large jump. The block is slewing when its last two recorded moves went the same way. The current code is always available as the conversion result.

Top module: `trk_adc_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the code is 0, `acquiring` is 1 and `locked` is 0.
- R2: During acquisition, an enabled clock with only `cmp_below` set raises the code by one. The first enabled clock with `cmp_below` clear (and the input valid) leaves the code unchanged and ends acquisition for good. Acquisition never lowers the code.
- R3: While tracking, an enabled clock with only `cmp_above` set lowers the code by one.
- R4: While tracking, an enabled clock with only `cmp_below` set raises the code by one.
- R5: An enabled clock with neither comparator flag set holds the code.
- R6: An enabled clock with both flags set is an invalid input. The code holds, the step is recorded as a hold, and the acquisition state is unchanged.
- R7: While `step_en` is 0, the code, `acquiring` and `locked` do not change, whatever the comparator flags are.
- R8: The code saturates. A raise request at 255 holds it at 255, a lower request at 0 holds it at 0, and either case is recorded as a hold.
- R9: Each enabled clock records one move: up, down or hold. `locked` is 0 during acquisition. After acquisition, `locked` is 0 exactly when the last two recorded moves are both up or both down, and 1 otherwise.
- R10: Tracking never ends. After the input jumps above or below the code, the code ramps one step per enabled clock toward the new level and settles there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Allows one compare-and-step on this clock |
| cmp_above | input | 1 | Test level is above the input |
| cmp_below | input | 1 | Test level is below the input |
| code | output | 8 | Current code driving the DAC |
| acquiring | output | 1 | Initial upward ramp still in progress |
| locked | output | 1 | Code is within one step of the input (not slewing) |

## Verification
Every input level from 0 to 255 is acquired from reset. This shows that the ramp stops exactly at the input and that acquisition time grows with the level. Some of these runs use a broken enable pattern, which separates enabled steps from idle clocks. Tracking is then tried three ways: with a steady input, which must hold and stay locked; with one-step nudges, which must keep the lock; and with large jumps both ways, which must drop the lock during the ramp and regain it on arrival. Comparator patterns driven directly cover the invalid both-set case and saturation at both ends of the code range. A bench model of the expected code and lock state is compared with the outputs on every clock.

// File: rtl/trk_pkg.sv
package trk_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_UP   = 2'd1,
    ACT_DN   = 2'd2
  } act_t;

  // Requested move from phase and comparator flags
  function automatic act_t pick_act(logic acq, logic above, logic below);
    if (above && below) return ACT_HOLD;
    if (acq)            return below ? ACT_UP : ACT_HOLD;
    if (below)          return ACT_UP;
    if (above)          return ACT_DN;
    return ACT_HOLD;
  endfunction

  // Two equal non-hold moves in a row mean the loop is slewing
  function automatic logic is_run(act_t newer, act_t older);
    return (newer == older) && (newer != ACT_HOLD);
  endfunction

endpackage

// File: rtl/trk_phase_ctl.sv
module trk_phase_ctl
  import trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic cmp_above,
  input  logic cmp_below,
  output logic acquiring,
  output act_t req_act
);

  logic input_bad;
  logic reach_evt;

  assign input_bad = cmp_above && cmp_below;
  assign reach_evt = step_en && acquiring && !input_bad && !cmp_below;
  assign req_act   = pick_act(acquiring, cmp_above, cmp_below);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acquiring <= 1'b1;
    else if (reach_evt) acquiring <= 1'b0;
  end

  // R2: once the input is reached, acquisition is over
  a_r2_acq_exit: assert property (@(posedge clk) disable iff (!rst_n)
    reach_evt |=> !acquiring);

  // R2: acquisition is never re-entered
  a_r2_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    !acquiring |=> !acquiring);

  // R6: an invalid input leaves the phase alone
  a_r6_phase_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && input_bad) |=> $stable(acquiring));

endmodule

// File: rtl/trk_updown_cnt.sv
module trk_updown_cnt
  import trk_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  act_t              req_act,
  output logic [CODE_W-1:0] code,
  output act_t              taken_act
);

  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;
  localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);

  logic at_top;
  logic at_bot;

  assign at_top = (code == CODE_MAX);
  assign at_bot = (code == CODE_MIN);

  always_comb begin
    taken_act = req_act;
    if ((req_act == ACT_UP && at_top) || (req_act == ACT_DN && at_bot))
      taken_act = ACT_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= CODE_MIN;
    end else if (step_en) begin
      case (taken_act)
        ACT_UP:  code <= code + ONE;
        ACT_DN:  code <= code - ONE;
        default: code <= code;
      endcase
    end
  end

  // R4 / R2: an up request below the top adds one
  a_r4_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && req_act == ACT_UP && !at_top) |=> code == $past(code) + ONE);

  // R3: a down request above zero subtracts one
  a_r3_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && req_act == ACT_DN && !at_bot) |=> code == $past(code) - ONE);

  // R8: saturation at both ends
  a_r8_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && req_act == ACT_UP && at_top) |=> code == CODE_MAX);
  a_r8_sat_bot: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && req_act == ACT_DN && at_bot) |=> code == CODE_MIN);

  // R7: idle clocks do not move the code
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(code));

  // R5: a hold request keeps the code
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && req_act == ACT_HOLD) |=> $stable(code));

endmodule

// File: rtl/trk_lock_mon.sv
module trk_lock_mon
  import trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic acquiring,
  input  act_t taken_act,
  output logic locked
);

  act_t last_act;
  act_t prev_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_act <= ACT_HOLD;
      prev_act <= ACT_HOLD;
    end else if (step_en) begin
      prev_act <= last_act;
      last_act <= taken_act;
    end
  end

  assign locked = !acquiring && !is_run(last_act, prev_act);

  // R9: a recorded hold restores the lock once tracking
  a_r9_hold_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && taken_act == ACT_HOLD) |=> (locked || acquiring));

  // R9: a repeated step direction drops the lock
  a_r9_run_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && taken_act != ACT_HOLD && taken_act == last_act) |=> !locked);

  // R9: no lock while still acquiring
  a_r9_acq_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    acquiring |-> !locked);

endmodule

// File: rtl/trk_adc_ctrl.sv
module trk_adc_ctrl
  import trk_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              cmp_above,
  input  logic              cmp_below,
  output logic [CODE_W-1:0] code,
  output logic              acquiring,
  output logic              locked
);

  act_t req_act;
  act_t taken_act;

  trk_phase_ctl u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .cmp_above (cmp_above),
    .cmp_below (cmp_below),
    .acquiring (acquiring),
    .req_act   (req_act)
  );

  trk_updown_cnt #(.CODE_W(CODE_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .req_act   (req_act),
    .code      (code),
    .taken_act (taken_act)
  );

  trk_lock_mon u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .acquiring (acquiring),
    .taken_act (taken_act),
    .locked    (locked)
  );

  // R6: both flags set never moves the code
  a_r6_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cmp_above && cmp_below) |=> $stable(code));

  // R2: the acquisition ramp never lowers the code
  a_r2_no_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && acquiring) |=> code >= $past(code));

  // R7: idle clocks change none of the outputs
  a_r7_outputs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(acquiring) && $stable(locked)));

endmodule

// File: tb/tb_trk_adc_ctrl.sv
module tb_trk_adc_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_en = 1'b0;
  logic       cmp_above = 1'b0;
  logic       cmp_below = 1'b0;
  logic [7:0] code;
  logic       acquiring;
  logic       locked;

  always #2 clk = ~clk;

  trk_adc_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .cmp_above (cmp_above),
    .cmp_below (cmp_below),
    .code      (code),
    .acquiring (acquiring),
    .locked    (locked)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Bench model; moves: 0 hold, 1 up, 2 down
  logic [7:0] vin;
  logic [7:0] m_code;
  logic       m_acq;
  int         h1, h2;

  function automatic logic m_locked();
    return !m_acq && !(h1 == h2 && h1 != 0);
  endfunction

  task automatic chk(string req);
    checks++;
    if (code !== m_code || acquiring !== m_acq || locked !== m_locked()) begin
      errors++;
      $display("FAIL %s: code=%0d acq=%0b lock=%0b expected code=%0d acq=%0b lock=%0b",
               req, code, acquiring, locked, m_code, m_acq, m_locked());
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step_en = 1'b0; cmp_above = 1'b0; cmp_below = 1'b0;
    m_code = 8'd0; m_acq = 1'b1; h1 = 0; h2 = 0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1");
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1");
  endtask

  task automatic raw_step(input logic en, input logic ab, input logic be, input string req);
    int act;
    step_en = en; cmp_above = ab; cmp_below = be;
    @(posedge clk); #1;
    if (en) begin
      act = 0;
      if (ab && be)     act = 0;
      else if (m_acq) begin
        if (be) act = 1;
        else    m_acq = 1'b0;
      end
      else if (be)      act = 1;
      else if (ab)      act = 2;
      if (act == 1 && m_code == 8'd255) act = 0;
      if (act == 2 && m_code == 8'd0)   act = 0;
      if (act == 1) m_code = m_code + 8'd1;
      if (act == 2) m_code = m_code - 8'd1;
      h2 = h1; h1 = act;
    end
    chk(req);
    step_en = 1'b0;
  endtask

  task automatic trk_step(input logic en, input string req);
    raw_step(en, m_code > vin, m_code < vin, req);
  endtask

  task automatic settle(input string req);
    for (int i = 0; i < 300 && (m_code != vin || m_acq); i++) trk_step(1'b1, req);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    vin = 8'd0;
    do_reset();

    // R2 sweep over every input level; R7 with a broken enable on some runs
    for (int v = 0; v < 256; v++) begin
      do_reset();
      vin = 8'(v);
      for (int i = 0; i < 400 && m_acq; i++)
        trk_step((v % 5 != 0) || (i % 3 != 0), (v % 5 == 0) ? "R7" : "R2");
      checks++;
      if (code !== vin || acquiring !== 1'b0) begin
        errors++;
        $display("FAIL R2: code=%0d acq=%0b expected code=%0d acq=0", code, acquiring, vin);
      end
    end

    // Tracking from 100
    do_reset();
    vin = 8'd100;
    settle("R2");
    repeat (4) trk_step(1'b1, "R5");
    vin = 8'd101; trk_step(1'b1, "R4");
    vin = 8'd100; trk_step(1'b1, "R3");
    vin = 8'd101; trk_step(1'b1, "R9");
    vin = 8'd100; trk_step(1'b1, "R9");

    // R10 large jumps both ways
    vin = 8'd200; repeat (5) trk_step(1'b1, "R10");
    settle("R10"); trk_step(1'b1, "R9");
    vin = 8'd20; repeat (5) trk_step(1'b1, "R10");
    settle("R10"); trk_step(1'b1, "R9");

    // R7 idle with requests applied
    repeat (3) raw_step(1'b0, 1'b1, 1'b0, "R7");
    repeat (3) raw_step(1'b0, 1'b0, 1'b1, "R7");

    // R6 invalid input while tracking after a run
    vin = 8'd40; repeat (3) trk_step(1'b1, "R10");
    repeat (3) raw_step(1'b1, 1'b1, 1'b1, "R6");

    // R6 invalid input during acquisition
    do_reset();
    vin = 8'd30;
    repeat (4) trk_step(1'b1, "R2");
    repeat (3) raw_step(1'b1, 1'b1, 1'b1, "R6");
    settle("R2");

    // R8 saturation at the top
    do_reset();
    vin = 8'd255;
    settle("R2");
    repeat (3) raw_step(1'b1, 1'b0, 1'b1, "R8");
    // R8 saturation at the bottom
    vin = 8'd0;
    settle("R10");
    repeat (3) raw_step(1'b1, 1'b1, 1'b0, "R8");
    raw_step(1'b1, 1'b0, 1'b1, "R4");
    raw_step(1'b1, 1'b1, 1'b0, "R3");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule